// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block arbitrates sixteen interrupt lines that belong to two eight-line controllers. Lines 0 to 7 are on the first controller. Lines 8 to 15 are on the second controller, which is chained into line 2 of the first. Requests arrive as one-cycle pulses and are held as pending bits. Each cycle a combinational resolver ranks the eligible lines on one flattened sixteen-level scale. The winner is offered to the processor as a vector with a request strobe. When the processor acknowledges the offer, the line's pending bit is cleared. Unless that controller ends interrupts automatically, the line also becomes in service and becomes the active level.

The active level gates nesting: a line may interrupt only if it outranks the level currently being served. A per-controller special-mask flag lifts that gate for the lines of its own controller. End-of-interrupt commands, nonspecific or naming one level, retire the active level. The next active level is then the highest-ranked line still in service, or none. Masks, flags, vector bases and the processor enable arrive as plain inputs; programming them is left to surrounding logic.

A two-state machine drives the offer. In ARB_IDLE a GRANT transition to ARB_OFFER happens when the processor enable is set and some line is eligible. The winner and its vector are latched on that edge. In ARB_OFFER there are two ways back to ARB_IDLE. An ACCEPT transition happens on acknowledge. A WITHDRAW transition happens if the enable drops or the held line stops being eligible; WITHDRAW takes precedence over ACCEPT.

Top module: `irq_cascade_arbiter`

## Requirements
- R1: After reset, all pending and in-service bits are zero, no active level exists and `int_req` is low.
- R2: A `req_pulse` bit seen at a clock edge sets that line's pending bit, visible after that edge. The bit stays set until the line is accepted. A new pulse in the accepting cycle keeps the bit set.
- R3: Rank from highest to lowest is lines 0, 1, 2, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. The highest-ranked eligible line wins the GRANT.
- R4: A line whose `line_mask` bit is 1 is never offered. Lines 8 to 15 are also never offered while `line_mask[2]` is 1; they stay pending and are offered once it clears.
- R5: No GRANT occurs while `cpu_ie` is 0. If `cpu_ie` is 0 during ARB_OFFER, WITHDRAW drops `int_req` on the next edge and the line stays pending.
- R6: With no special mask, a line is eligible only if it strictly outranks the active level; with no active level every rank qualifies. `int_req` rises one edge after a line becomes eligible in ARB_IDLE.
- R7: When `spec_mask[c]` is 1 (c=0 for lines 0-7, c=1 for lines 8-15), lines of controller c skip the active-level comparison.
- R8: `int_vec` is {base[4:0], line[2:0]}, where base is `vbase_mst` for lines 0-7 and `vbase_slv` for lines 8-15. It is latched at GRANT and holds while `int_req` is high.
- R9: ACCEPT clears the held line's pending bit. If `auto_eoi` of its controller is 0, the line's in-service bit is set and it becomes the active level. Otherwise in-service and the active level are unchanged.
- R10: A nonspecific EOI (`eoi_specific`=0) clears the active level's in-service bit only when the active level belongs to controller `eoi_ctrl` (0 first, 1 second).
- R11: A specific EOI acts only when line {eoi_ctrl, eoi_level} equals the active level; otherwise nothing changes.
- R12: After an EOI takes effect, the active level becomes the highest-ranked line still in service, or none. An EOI in the same cycle as ACCEPT is applied before the accepted line is added.
- R13: `int_ack` outside ARB_OFFER, and an EOI that does not match, change no pending, in-service or active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 16 | One-cycle request pulse per line |
| line_mask | input | 16 | Per-line mask, 1 blocks the line |
| spec_mask | input | 2 | Special-mask flag per controller |
| auto_eoi | input | 2 | Automatic end-of-interrupt per controller |
| cpu_ie | input | 1 | Processor interrupt enable |
| vbase_mst | input | 5 | Vector base, upper five bits, lines 0-7 |
| vbase_slv | input | 5 | Vector base, upper five bits, lines 8-15 |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_ctrl | input | 1 | Issuing controller, 0 first, 1 second |
| eoi_specific | input | 1 | 1 names a level, 0 nonspecific |
| eoi_level | input | 3 | Named level within the controller |
| int_ack | input | 1 | Processor acknowledge |
| int_req | output | 1 | Interrupt offer strobe |
| int_vec | output | 8 | Offered vector |
| pend_o | output | 16 | Pending bits |
| insvc_o | output | 16 | In-service bits |
| act_valid | output | 1 | An active level exists |
| act_line | output | 4 | Active level line number |

## Verification
Pending bits change on the edge that samples a pulse. The offer appears one edge later, or on the edge where a blocking mask, enable or nesting condition is lifted. ACCEPT, WITHDRAW and EOI effects are visible right after the edge that samples the command. The bench drives inputs just after a rising edge and samples all outputs just after the next one. A bench reference model is stepped once per edge from the same inputs, so each comparison lines up with the cycle in which the result is due. Directed sequences pin down rank, gating, nesting, special mask, auto-EOI and both EOI forms with literal values. A seeded random run follows.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PER_CTRL  = 8;
    localparam int NCTRL     = 2;
    localparam int NLINES    = PER_CTRL * NCTRL;
    localparam int LINE_W    = $clog2(NLINES);
    localparam int LOW_W     = $clog2(PER_CTRL);
    localparam int RANK_W    = $clog2(NLINES + 1);
    localparam int CASC      = 2;
    localparam int IDLE_RANK = NLINES;
    localparam int VEC_W     = 8;
    localparam int VBASE_W   = VEC_W - LOW_W;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [RANK_W-1:0] rank_t;

    typedef enum logic {
        ARB_IDLE,
        ARB_OFFER
    } arb_state_e;

    // Flattened rank: 0 is highest. Second-controller lines slot in just
    // below the cascade line of the first controller.
    function automatic rank_t line_rank(line_t l);
        int li;
        li = int'(l);
        if (li <= CASC)
            return rank_t'(li);
        else if (li >= PER_CTRL)
            return rank_t'(li - PER_CTRL + CASC + 1);
        else
            return rank_t'(li + PER_CTRL);
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_arb_pkg::*;
(
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] mask,
    input  logic [NCTRL-1:0]  smm,
    input  logic              act_valid,
    input  line_t             act_line,
    output logic [NLINES-1:0] elig,
    output logic              win_valid,
    output line_t             win_line
);
    rank_t act_rank;
    rank_t best_rank;

    assign act_rank = act_valid ? line_rank(act_line) : rank_t'(IDLE_RANK);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam int CTRL = g / PER_CTRL;
        logic casc_open;
        logic nest_ok;
        assign casc_open = (CTRL == 0) || !mask[CASC];
        assign nest_ok   = (line_rank(line_t'(g)) < act_rank) || smm[CTRL];
        assign elig[g]   = pend[g] && !mask[g] && casc_open && nest_ok;
    end

    always_comb begin
        best_rank = rank_t'(IDLE_RANK);
        win_line  = '0;
        for (int l = 0; l < NLINES; l++) begin
            if (elig[l] && (line_rank(line_t'(l)) < best_rank)) begin
                best_rank = line_rank(line_t'(l));
                win_line  = line_t'(l);
            end
        end
        win_valid = (best_rank != rank_t'(IDLE_RANK));
    end
endmodule

// File: rtl/irq_eoi.sv
module irq_eoi
    import irq_arb_pkg::*;
(
    input  logic [NLINES-1:0] insvc,
    input  logic              act_valid,
    input  line_t             act_line,
    input  logic              eoi_valid,
    input  logic              eoi_ctrl,
    input  logic              eoi_specific,
    input  logic [LOW_W-1:0]  eoi_level,
    output logic [NLINES-1:0] insvc_nx,
    output logic              act_valid_nx,
    output line_t             act_line_nx,
    output logic              eoi_hit
);
    logic  owner_ok;
    logic  level_ok;
    rank_t sel_rank;

    assign owner_ok = (act_line[LINE_W-1] == eoi_ctrl);
    assign level_ok = !eoi_specific || (act_line[LOW_W-1:0] == eoi_level);
    assign eoi_hit  = eoi_valid && act_valid && owner_ok && level_ok;

    always_comb begin
        insvc_nx     = insvc;
        act_valid_nx = act_valid;
        act_line_nx  = act_line;
        sel_rank     = rank_t'(IDLE_RANK);
        if (eoi_hit) begin
            insvc_nx[act_line] = 1'b0;
            act_valid_nx       = 1'b0;
            for (int l = 0; l < NLINES; l++) begin
                if (insvc_nx[l] && (line_rank(line_t'(l)) < sel_rank)) begin
                    sel_rank     = line_rank(line_t'(l));
                    act_line_nx  = line_t'(l);
                    act_valid_nx = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_cascade_arbiter.sv
module irq_cascade_arbiter
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        req_pulse,
    input  logic [15:0]        line_mask,
    input  logic [1:0]         spec_mask,
    input  logic [1:0]         auto_eoi,
    input  logic               cpu_ie,
    input  logic [4:0]         vbase_mst,
    input  logic [4:0]         vbase_slv,
    input  logic               eoi_valid,
    input  logic               eoi_ctrl,
    input  logic               eoi_specific,
    input  logic [2:0]         eoi_level,
    input  logic               int_ack,
    output logic               int_req,
    output logic [7:0]         int_vec,
    output logic [15:0]        pend_o,
    output logic [15:0]        insvc_o,
    output logic               act_valid,
    output logic [3:0]         act_line
);
    arb_state_e        state_q, state_d;
    line_t             held_q;
    logic [VEC_W-1:0]  vec_q;
    logic [NLINES-1:0] pend_q, insvc_q;
    logic              actv_q;
    line_t             act_q;

    logic [NLINES-1:0] elig;
    logic              win_valid;
    line_t             win_line;
    logic [NLINES-1:0] ins_eoi;
    logic              actv_eoi;
    line_t             act_eoi;
    logic              eoi_hit;

    logic              grant, accept, held_ok, keep_svc;
    logic [NLINES-1:0] start_mask;

    irq_pick u_pick (
        .pend      (pend_q),
        .mask      (line_mask),
        .smm       (spec_mask),
        .act_valid (actv_q),
        .act_line  (act_q),
        .elig      (elig),
        .win_valid (win_valid),
        .win_line  (win_line)
    );

    irq_eoi u_eoi (
        .insvc        (insvc_q),
        .act_valid    (actv_q),
        .act_line     (act_q),
        .eoi_valid    (eoi_valid),
        .eoi_ctrl     (eoi_ctrl),
        .eoi_specific (eoi_specific),
        .eoi_level    (eoi_level),
        .insvc_nx     (ins_eoi),
        .act_valid_nx (actv_eoi),
        .act_line_nx  (act_eoi),
        .eoi_hit      (eoi_hit)
    );

    assign held_ok    = elig[held_q];
    assign keep_svc   = !auto_eoi[held_q[LINE_W-1]];
    assign start_mask = accept ? ({{(NLINES-1){1'b0}}, 1'b1} << held_q) : '0;

    // Next-state logic: GRANT, ACCEPT, WITHDRAW
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (cpu_ie && win_valid) begin
                    state_d = ARB_OFFER;
                    grant   = 1'b1;
                end
            end
            ARB_OFFER: begin
                if (!cpu_ie || !held_ok) begin
                    state_d = ARB_IDLE;
                end else if (int_ack) begin
                    state_d = ARB_IDLE;
                    accept  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            vec_q   <= '0;
            pend_q  <= '0;
            insvc_q <= '0;
            actv_q  <= 1'b0;
            act_q   <= '0;
        end else begin
            if (grant) begin
                held_q <= win_line;
                vec_q  <= {(win_line[LINE_W-1] ? vbase_slv : vbase_mst),
                           win_line[LOW_W-1:0]};
            end
            pend_q <= (pend_q & ~start_mask) | req_pulse;
            if (accept && keep_svc) begin
                insvc_q <= ins_eoi | start_mask;
                actv_q  <= 1'b1;
                act_q   <= held_q;
            end else begin
                insvc_q <= ins_eoi;
                actv_q  <= actv_eoi;
                act_q   <= act_eoi;
            end
        end
    end

    assign int_req   = (state_q == ARB_OFFER);
    assign int_vec   = vec_q;
    assign pend_o    = pend_q;
    assign insvc_o   = insvc_q;
    assign act_valid = actv_q;
    assign act_line  = act_q;

    // R5
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ie |=> !$rose(int_req));
    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack && cpu_ie) |=> (!int_req || $stable(int_vec)));
    // R9
    act_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> insvc_o[act_line]);
    // R12
    svc_has_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_o != '0) |-> act_valid);
    // R4
    casc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && win_line[LINE_W-1]) |-> !line_mask[CASC]);
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_pulse[held_q]) |=> !pend_o[$past(held_q)]);
    // R10
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !accept) |=> !insvc_o[$past(act_line)]);
endmodule

// File: tb/tb_irq_cascade_arbiter.sv
`timescale 1ns/1ps
module tb_irq_cascade_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_pulse, line_mask;
    logic [1:0]  spec_mask, auto_eoi;
    logic        cpu_ie;
    logic [4:0]  vbase_mst, vbase_slv;
    logic        eoi_valid, eoi_ctrl, eoi_specific;
    logic [2:0]  eoi_level;
    logic        int_ack;
    logic        int_req;
    logic [7:0]  int_vec;
    logic [15:0] pend_o, insvc_o;
    logic        act_valid;
    logic [3:0]  act_line;

    irq_cascade_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .line_mask(line_mask),
        .spec_mask(spec_mask), .auto_eoi(auto_eoi), .cpu_ie(cpu_ie),
        .vbase_mst(vbase_mst), .vbase_slv(vbase_slv), .eoi_valid(eoi_valid),
        .eoi_ctrl(eoi_ctrl), .eoi_specific(eoi_specific), .eoi_level(eoi_level),
        .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec), .pend_o(pend_o),
        .insvc_o(insvc_o), .act_valid(act_valid), .act_line(act_line)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [15:0] m_pend, m_ins;
    logic        m_actv, m_off;
    logic [3:0]  m_act, m_held;
    logic [7:0]  m_vec;

    int prio_list [16] = '{0, 1, 2, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};

    function automatic int rk(int l);
        for (int i = 0; i < 16; i++) if (prio_list[i] == l) return i;
        return 16;
    endfunction

    function automatic logic ok_line(int l);
        int cur;
        cur = m_actv ? rk(int'(m_act)) : 16;
        if (!m_pend[l] || line_mask[l]) return 1'b0;
        if (l >= 8 && line_mask[2]) return 1'b0;
        return (rk(l) < cur) || spec_mask[l / 8];
    endfunction

    function automatic int pick();
        for (int i = 0; i < 16; i++) if (ok_line(prio_list[i])) return prio_list[i];
        return -1;
    endfunction

    task automatic model_step();
        logic [15:0] ins1, clr;
        logic        av1;
        logic [3:0]  a1;
        int          w;
        ins1 = m_ins; av1 = m_actv; a1 = m_act; clr = '0;
        if (eoi_valid && m_actv && (m_act[3] == eoi_ctrl) &&
            (!eoi_specific || (m_act[2:0] == eoi_level))) begin
            ins1[m_act] = 1'b0;
            av1 = 1'b0;
            for (int i = 0; i < 16; i++)
                if (!av1 && ins1[prio_list[i]]) begin av1 = 1'b1; a1 = 4'(prio_list[i]); end
        end
        if (m_off) begin
            if (!cpu_ie || !ok_line(int'(m_held))) m_off = 1'b0;
            else if (int_ack) begin
                clr[m_held] = 1'b1;
                if (!auto_eoi[m_held[3]]) begin ins1[m_held] = 1'b1; av1 = 1'b1; a1 = m_held; end
                m_off = 1'b0;
            end
        end else begin
            w = pick();
            if (cpu_ie && w >= 0) begin
                m_off  = 1'b1;
                m_held = 4'(w);
                m_vec  = {(w >= 8) ? vbase_slv : vbase_mst, 3'(w % 8)};
            end
        end
        m_pend = (m_pend & ~clr) | req_pulse;
        m_ins  = ins1; m_actv = av1; m_act = a1;
    endtask

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2 pending", pend_o, m_pend);
        chk("R9 in-service", insvc_o, m_ins);
        chk("R10 active valid", 16'(act_valid), 16'(m_actv));
        if (m_actv) chk("R12 active line", 16'(act_line), 16'(m_act));
        chk("R6 offer", 16'(int_req), 16'(m_off));
        if (m_off) chk("R8 vector", 16'(int_vec), 16'(m_vec));
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        cmp_all();
        req_pulse = '0; int_ack = 1'b0; eoi_valid = 1'b0;
    endtask

    task automatic eoi(logic c, logic s, logic [2:0] lv);
        eoi_valid = 1'b1; eoi_ctrl = c; eoi_specific = s; eoi_level = lv;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_pulse = '0; line_mask = '0; spec_mask = '0; auto_eoi = '0;
        cpu_ie = 1'b1; vbase_mst = 5'h01; vbase_slv = 5'h0E;
        eoi_valid = 1'b0; eoi_ctrl = 1'b0; eoi_specific = 1'b0; eoi_level = '0; int_ack = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pending", pend_o, 16'h0);
        chk("R1 reset in-service", insvc_o, 16'h0);
        chk("R1 reset active", 16'(act_valid), 16'h0);
        chk("R1 reset offer", 16'(int_req), 16'h0);
        m_pend = '0; m_ins = '0; m_actv = 0; m_off = 0; m_act = '0; m_held = '0; m_vec = '0;
        rst_n = 1'b1;

        // R3: slave line 9 outranks master line 3
        req_pulse = 16'h0208; cyc();
        chk("R2 pend set", pend_o, 16'h0208);
        cyc();
        chk("R3 winner vec", 16'(int_vec), 16'h71);
        int_ack = 1'b1; cyc();
        chk("R9 accept insvc", insvc_o, 16'h0200);
        chk("R9 accept pend", pend_o, 16'h0008);
        cyc(); cyc();
        chk("R6 lower rank held off", 16'(int_req), 16'h0);
        eoi(1'b0, 1'b0, 3'd0); cyc();
        chk("R13 foreign eoi ignored", insvc_o, 16'h0200);
        eoi(1'b1, 1'b0, 3'd0); cyc();
        chk("R10 nonspecific eoi", insvc_o, 16'h0);
        chk("R10 idle after eoi", 16'(act_valid), 16'h0);
        cyc();
        chk("R6 idle lets line 3", 16'(int_vec), 16'h0B);
        int_ack = 1'b1; cyc();

        // R11/R12: specific EOI and reselect
        req_pulse = 16'h0001; cyc(); cyc();
        chk("R6 higher rank nests", 16'(int_vec), 16'h08);
        int_ack = 1'b1; cyc();
        chk("R9 nested insvc", insvc_o, 16'h0009);
        eoi(1'b0, 1'b1, 3'd3); cyc();
        chk("R11 nonmatching specific", insvc_o, 16'h0009);
        eoi(1'b0, 1'b1, 3'd0); cyc();
        chk("R11 matching specific", insvc_o, 16'h0008);
        chk("R12 reselect", 16'(act_line), 16'h3);

        // R7: special mask lets lower rank line 5 in
        spec_mask = 2'b01; req_pulse = 16'h0020; cyc(); cyc();
        chk("R7 special mask offer", 16'(int_vec), 16'h0D);
        int_ack = 1'b1; cyc();
        chk("R7 active 5", 16'(act_line), 16'h5);
        spec_mask = 2'b00;
        eoi(1'b0, 1'b0, 3'd0); cyc();
        chk("R12 back to 3", 16'(act_line), 16'h3);
        eoi(1'b0, 1'b0, 3'd0); cyc();

        // R4: cascade mask
        line_mask = 16'h0004; req_pulse = 16'h0400; cyc(); cyc(); cyc();
        chk("R4 slave gated", 16'(int_req), 16'h0);
        line_mask = 16'h0; cyc();
        chk("R4 slave released", 16'(int_vec), 16'h72);
        cyc(); cyc();
        chk("R8 vector held", 16'(int_vec), 16'h72);
        int_ack = 1'b1; cyc();
        eoi(1'b1, 1'b1, 3'd2); cyc();
        chk("R11 slave specific", insvc_o, 16'h0);

        // R5: processor enable
        cpu_ie = 1'b0; req_pulse = 16'h0002; cyc(); cyc(); cyc();
        chk("R5 no grant", 16'(int_req), 16'h0);
        cpu_ie = 1'b1; cyc();
        chk("R5 grant", 16'(int_vec), 16'h09);
        cpu_ie = 1'b0; cyc();
        chk("R5 withdraw", 16'(int_req), 16'h0);
        chk("R5 still pending", pend_o, 16'h0002);
        cpu_ie = 1'b1; cyc();
        int_ack = 1'b1; cyc();
        eoi(1'b0, 1'b0, 3'd0); cyc();

        // R9: auto EOI
        auto_eoi = 2'b01; req_pulse = 16'h0010; cyc(); cyc();
        int_ack = 1'b1; cyc();
        chk("R9 auto eoi insvc", insvc_o, 16'h0);
        chk("R9 auto eoi pend", pend_o, 16'h0);
        auto_eoi = 2'b00;

        // R13: stray acknowledge
        int_ack = 1'b1; cyc();
        chk("R13 stray ack", pend_o | insvc_o, 16'h0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            if (k % 64 == 0) begin
                line_mask = 16'($urandom & $urandom & $urandom);
                spec_mask = 2'($urandom % 4 == 0 ? $urandom : 0);
                auto_eoi  = 2'($urandom % 3 == 0 ? $urandom : 0);
                vbase_mst = 5'($urandom); vbase_slv = 5'($urandom);
            end
            cpu_ie = ($urandom % 8) != 0;
            req_pulse = ($urandom % 4 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
            int_ack = ($urandom % 3 == 0);
            if ($urandom % 5 == 0)
                eoi(1'($urandom), 1'($urandom),
                    ($urandom % 2 == 0) ? m_act[2:0] : 3'($urandom));
            cyc();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule